// File: doc/BRIEF.md
# Oversampled Serial Receiver

This block turns a serial input line into parallel data words. In asynchronous mode an external enable marks five sampling instants per bit period. A falling edge on the idle line is taken as a possible start bit and restarts the sampling phase, so that each group of five samples lines up with the bit cell that follows the edge. Each bit takes the majority value of its five samples, so a short disturbance on the line does not change the bit. In synchronous mode the five-sample stage is switched off and each bit is read on a rising edge of an external serial clock.

A frame is a low start bit, 5 to 8 data bits sent least significant bit first, an optional parity bit and a stop bit. When a frame completes, the word goes to the receive data register and the full flag is set. Parity, framing and overrun flags report problems with the most recent frame. An interrupt request follows the full flag while the interrupt enable is high. A one-cycle read strobe tells the block that the word has been consumed.

Top module: `serial_rx_os`

## Requirements
- R1: After a synchronous reset, `rx_data` is zero and `rx_full`, `err_parity`, `err_frame`, `err_overrun` and `rx_irq` are all low.
- R2: In asynchronous mode (`sync_mode`=0) a frame is a low start bit, then 5+`cfg_len` data bits least significant bit first, then a parity bit if `par_en`=1, then a stop bit. On completion `rx_data` holds the word right-justified with the unused upper bits zero, and `rx_full` rises.
- R3: Each asynchronous bit resolves to the majority of the five line samples taken on consecutive `tick_en` pulses. Two disturbed samples in a bit do not change the received word.
- R4: If the start bit's five samples resolve high, the start is rejected and the receiver returns to idle without delivering a word. A later valid frame is still received.
- R5: A falling edge on the idle line restarts the sampling phase, so correct reception does not depend on the number of `tick_en` pulses that occur while the line is idle.
- R6: With `par_en`=1, the parity bit makes the count of ones in data plus parity even when `par_odd`=0 and odd when `par_odd`=1. `err_parity` is high after a frame whose parity bit does not match and low after a frame whose parity bit matches.
- R7: `err_frame` is high after a frame whose stop bit resolves low, and the word is still delivered.
- R8: A word completing while `rx_full` is already high sets `err_overrun` and replaces `rx_data` with the newer word.
- R9: A one-cycle `rd_ack` pulse clears `rx_full` and `err_overrun`.
- R10: In synchronous mode (`sync_mode`=1) each bit is read once on a rising edge of `sclk_in`. The first low bit read while idle is the start bit, and the frame otherwise follows R2 and R6.
- R11: `rx_irq` is high while `rx_full` is high, provided `irq_en` was high in the previous cycle. It rises in the same cycle as `rx_full` when `irq_en` is held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_mode | input | 1 | 1: bits read on serial clock; 0: five-sample asynchronous mode |
| sclk_in | input | 1 | External serial clock for synchronous mode |
| tick_en | input | 1 | Sampling enable, five pulses per bit period |
| rxd | input | 1 | Serial data line, idles high |
| cfg_len | input | 2 | Data bits minus five |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1: odd parity, 0: even parity |
| irq_en | input | 1 | Receive interrupt enable |
| rd_ack | input | 1 | Word consumed; clears full and overrun |
| rx_data | output | 8 | Receive data register |
| rx_full | output | 1 | Unread word present |
| err_parity | output | 1 | Parity mismatch in the last frame |
| err_frame | output | 1 | Stop bit low in the last frame |
| err_overrun | output | 1 | Word completed while full |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
A sampling phase that is out of step with the start edge shows up at once as a shifted or corrupted word. Within one frame it also tends to show up as a false framing or parity flag, because the stop and parity bits then come from the wrong bit cell. A bit counter or length latch in the wrong state delivers a word that is too short or too long, and the stop bit is read in the wrong place, so `err_frame` goes wrong on the same frame. A wrong flag state in the result register is visible on the next completed frame or on the cycle after a read strobe, because overrun, full and interrupt must change together with it.

// File: rtl/rx_pkg.sv
package rx_pkg;
  typedef enum logic [2:0] {
    RX_IDLE  = 3'd0,
    RX_START = 3'd1,
    RX_DATA  = 3'd2,
    RX_PAR   = 3'd3,
    RX_STOP  = 3'd4
  } rx_state_t;
endpackage

// File: rtl/rx_os_filter.sv
// Input synchronizers, sampling phase counter and majority vote.
module rx_os_filter #(
  parameter int OS_N   = 5,
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sync_mode,
  input  logic tick_en,
  input  logic sclk_in,
  input  logic rxd_in,
  input  logic reload,
  output logic line_s,
  output logic bit_valid,
  output logic bit_val
);
  localparam int CW = (OS_N > 1) ? $clog2(OS_N) : 1;

  logic [SYNC_N-1:0] rxd_sr;
  logic [SYNC_N-1:0] sclk_sr;
  logic              sclk_prev;
  logic [CW-1:0]     phase;
  logic [OS_N-1:0]   samples;
  logic [OS_N-1:0]   samples_nx;
  logic              sclk_s;

  assign line_s     = rxd_sr[SYNC_N-1];
  assign sclk_s     = sclk_sr[SYNC_N-1];
  assign samples_nx = {samples[OS_N-2:0], line_s};

  function automatic logic vote(input logic [OS_N-1:0] s);
    int ones;
    ones = 0;
    for (int i = 0; i < OS_N; i++) ones += int'(s[i]);
    return ones > (OS_N / 2);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      rxd_sr    <= '1;
      sclk_sr   <= '0;
      sclk_prev <= 1'b0;
    end else begin
      rxd_sr    <= {rxd_sr[SYNC_N-2:0], rxd_in};
      sclk_sr   <= {sclk_sr[SYNC_N-2:0], sclk_in};
      sclk_prev <= sclk_s;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= '0;
      samples   <= '0;
      bit_valid <= 1'b0;
      bit_val   <= 1'b1;
    end else begin
      bit_valid <= 1'b0;
      if (sync_mode) begin
        phase   <= '0;
        samples <= '0;
        if (sclk_s && !sclk_prev) begin
          bit_valid <= 1'b1;
          bit_val   <= line_s;
        end
      end else if (reload) begin
        phase   <= '0;
        samples <= '0;
      end else if (tick_en) begin
        samples <= samples_nx;
        if (phase == CW'(OS_N - 1)) begin
          phase     <= '0;
          bit_valid <= 1'b1;
          bit_val   <= vote(samples_nx);
        end else begin
          phase <= phase + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rx_frame_fsm.sv
// Frame sequencing: start detection, data assembly, parity, stop.
module rx_frame_fsm
  import rx_pkg::*;
#(
  parameter int MAX_BITS = 8,
  parameter int LEN_W    = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sync_mode,
  input  logic                line_s,
  input  logic                bit_valid,
  input  logic                bit_val,
  input  logic [LEN_W-1:0]    cfg_len,
  input  logic                par_en,
  input  logic                par_odd,
  output logic                reload,
  output logic                done,
  output logic [MAX_BITS-1:0] word,
  output logic                perr,
  output logic                ferr
);
  localparam int MIN_BITS = MAX_BITS - (1 << LEN_W) + 1;
  localparam int CNT_W    = $clog2(MAX_BITS);

  rx_state_t          state;
  logic               line_prev;
  logic               fall;
  logic [CNT_W-1:0]   bitcnt;
  logic [CNT_W-1:0]   last_q;
  logic               pen_q;
  logic               podd_q;
  logic               acc;
  logic [MAX_BITS-1:0] shreg;

  assign fall   = line_prev && !line_s;
  assign reload = (state == RX_IDLE) && !sync_mode && fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= RX_IDLE;
      line_prev <= 1'b1;
      bitcnt    <= '0;
      last_q    <= '0;
      pen_q     <= 1'b0;
      podd_q    <= 1'b0;
      acc       <= 1'b0;
      shreg     <= '0;
      done      <= 1'b0;
      word      <= '0;
      perr      <= 1'b0;
      ferr      <= 1'b0;
    end else begin
      line_prev <= line_s;
      done      <= 1'b0;
      unique case (state)
        RX_IDLE: begin
          if ((!sync_mode && fall) || (sync_mode && bit_valid && !bit_val)) begin
            state  <= sync_mode ? RX_DATA : RX_START;
            last_q <= CNT_W'(MIN_BITS - 1) + CNT_W'(cfg_len);
            pen_q  <= par_en;
            podd_q <= par_odd;
            bitcnt <= '0;
            acc    <= 1'b0;
            shreg  <= '0;
            perr   <= 1'b0;
          end
        end
        RX_START: begin
          if (bit_valid) state <= bit_val ? RX_IDLE : RX_DATA;
        end
        RX_DATA: begin
          if (bit_valid) begin
            shreg[bitcnt] <= bit_val;
            acc           <= acc ^ bit_val;
            if (bitcnt == last_q) begin
              bitcnt <= '0;
              state  <= pen_q ? RX_PAR : RX_STOP;
            end else begin
              bitcnt <= bitcnt + 1'b1;
            end
          end
        end
        RX_PAR: begin
          if (bit_valid) begin
            perr  <= (acc ^ bit_val) != podd_q;
            state <= RX_STOP;
          end
        end
        RX_STOP: begin
          if (bit_valid) begin
            done  <= 1'b1;
            word  <= shreg;
            ferr  <= !bit_val;
            state <= RX_IDLE;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rx_result.sv
// Receive data register, status flags and interrupt request.
module rx_result #(
  parameter int MAX_BITS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                done,
  input  logic [MAX_BITS-1:0] word,
  input  logic                perr,
  input  logic                ferr,
  input  logic                rd_ack,
  input  logic                irq_en,
  output logic [MAX_BITS-1:0] rx_data,
  output logic                rx_full,
  output logic                err_parity,
  output logic                err_frame,
  output logic                err_overrun,
  output logic                rx_irq
);
  logic full_nx;
  logic ovr_nx;

  always_comb begin
    full_nx = rx_full;
    ovr_nx  = err_overrun;
    if (done) begin
      full_nx = 1'b1;
      if (rx_full && !rd_ack) ovr_nx = 1'b1;
      else if (rd_ack)        ovr_nx = 1'b0;
    end else if (rd_ack) begin
      full_nx = 1'b0;
      ovr_nx  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data     <= '0;
      rx_full     <= 1'b0;
      err_parity  <= 1'b0;
      err_frame   <= 1'b0;
      err_overrun <= 1'b0;
      rx_irq      <= 1'b0;
    end else begin
      rx_full     <= full_nx;
      err_overrun <= ovr_nx;
      rx_irq      <= irq_en && full_nx;
      if (done) begin
        rx_data    <= word;
        err_parity <= perr;
        err_frame  <= ferr;
      end
    end
  end
endmodule

// File: rtl/serial_rx_os.sv
module serial_rx_os #(
  parameter int DATA_MAX = 8,
  parameter int LEN_W    = 2,
  parameter int OS_N     = 5,
  parameter int SYNC_N   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sync_mode,
  input  logic                sclk_in,
  input  logic                tick_en,
  input  logic                rxd,
  input  logic [LEN_W-1:0]    cfg_len,
  input  logic                par_en,
  input  logic                par_odd,
  input  logic                irq_en,
  input  logic                rd_ack,
  output logic [DATA_MAX-1:0] rx_data,
  output logic                rx_full,
  output logic                err_parity,
  output logic                err_frame,
  output logic                err_overrun,
  output logic                rx_irq
);
  logic                line_s;
  logic                bit_valid;
  logic                bit_val;
  logic                reload;
  logic                frame_done;
  logic [DATA_MAX-1:0] frame_word;
  logic                frame_perr;
  logic                frame_ferr;

  rx_os_filter #(.OS_N(OS_N), .SYNC_N(SYNC_N)) u_filt (
    .clk(clk), .rst(rst), .sync_mode(sync_mode), .tick_en(tick_en),
    .sclk_in(sclk_in), .rxd_in(rxd), .reload(reload),
    .line_s(line_s), .bit_valid(bit_valid), .bit_val(bit_val)
  );

  rx_frame_fsm #(.MAX_BITS(DATA_MAX), .LEN_W(LEN_W)) u_fsm (
    .clk(clk), .rst(rst), .sync_mode(sync_mode), .line_s(line_s),
    .bit_valid(bit_valid), .bit_val(bit_val), .cfg_len(cfg_len),
    .par_en(par_en), .par_odd(par_odd), .reload(reload),
    .done(frame_done), .word(frame_word), .perr(frame_perr), .ferr(frame_ferr)
  );

  rx_result #(.MAX_BITS(DATA_MAX)) u_res (
    .clk(clk), .rst(rst), .done(frame_done), .word(frame_word),
    .perr(frame_perr), .ferr(frame_ferr), .rd_ack(rd_ack), .irq_en(irq_en),
    .rx_data(rx_data), .rx_full(rx_full), .err_parity(err_parity),
    .err_frame(err_frame), .err_overrun(err_overrun), .rx_irq(rx_irq)
  );
endmodule

// File: rtl/rx_checker.sv
module rx_checker #(
  parameter int DATA_MAX = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                rd_ack,
  input logic                irq_en,
  input logic                frame_done,
  input logic [DATA_MAX-1:0] rx_data,
  input logic                rx_full,
  input logic                err_overrun,
  input logic                rx_irq
);
  AST_DONE_SETS_FULL: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> rx_full); // R2
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !frame_done |=> $stable(rx_data)); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done); // R2
  AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (rst)
    err_overrun |-> rx_full); // R8
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd_ack && !frame_done) |=> (!rx_full && !err_overrun)); // R9
  AST_IRQ_NEEDS_FULL: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> rx_full); // R11
  AST_IRQ_ON_DONE: assert property (@(posedge clk) disable iff (rst)
    (irq_en && frame_done) |=> rx_irq); // R11
endmodule

bind serial_rx_os rx_checker #(.DATA_MAX(DATA_MAX)) u_chk (.*);

// File: tb/sim_serial_rx_os.sv
module sim_serial_rx_os;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sync_mode = 1'b0;
  logic       sclk_in = 1'b0;
  logic       tick_en = 1'b0;
  logic       rxd = 1'b1;
  logic [1:0] cfg_len = 2'd3;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic       irq_en = 1'b0;
  logic       rd_ack = 1'b0;
  logic [7:0] rx_data;
  logic       rx_full, err_parity, err_frame, err_overrun, rx_irq;

  int total = 0;
  int fails = 0;
  int tdiv  = 0;

  serial_rx_os u0 (
    .clk(clk), .rst(rst), .sync_mode(sync_mode), .sclk_in(sclk_in),
    .tick_en(tick_en), .rxd(rxd), .cfg_len(cfg_len), .par_en(par_en),
    .par_odd(par_odd), .irq_en(irq_en), .rd_ack(rd_ack), .rx_data(rx_data),
    .rx_full(rx_full), .err_parity(err_parity), .err_frame(err_frame),
    .err_overrun(err_overrun), .rx_irq(rx_irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(negedge clk) begin
    tdiv    <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
    tick_en <= (tdiv == TICK_DIV - 1);
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick_wait(input int n);
    repeat (n) begin
      @(posedge clk);
      while (!tick_en) @(posedge clk);
    end
    @(negedge clk);
  endtask

  task automatic a_bit(input logic v, input bit gl);
    if (!gl) begin
      rxd = v; tick_wait(5);
    end else begin
      rxd = v;  tick_wait(1);
      rxd = ~v; tick_wait(1);
      rxd = v;  tick_wait(1);
      rxd = ~v; tick_wait(1);
      rxd = v;  tick_wait(1);
    end
  endtask

  function automatic logic [7:0] lmask(input int lc);
    return 8'((1 << (5 + lc)) - 1);
  endfunction

  function automatic logic pbit_of(input logic [7:0] w, input int lc, input int pm);
    logic p;
    p = ^(w & lmask(lc));
    return (pm == 2) ? ~p : p;
  endfunction

  // pm: 0 none, 1 even, 2 odd
  task automatic a_frame(input logic [7:0] w, input int lc, input int pm,
                         input bit flip, input logic stopv, input bit gl,
                         input int offset);
    cfg_len = 2'(lc);
    par_en  = (pm != 0);
    par_odd = (pm == 2);
    rxd = 1'b1;
    tick_wait(1 + offset);
    a_bit(1'b0, 1'b0);
    for (int i = 0; i < 5 + lc; i++) a_bit(w[i], gl);
    if (pm != 0) a_bit(pbit_of(w, lc, pm) ^ flip, 1'b0);
    a_bit(stopv, 1'b0);
    rxd = 1'b1;
    if (!stopv) tick_wait(2);
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic s_bit(input logic v);
    @(negedge clk); rxd = v;
    repeat (3) @(negedge clk);
    sclk_in = 1'b1;
    repeat (4) @(negedge clk);
    sclk_in = 1'b0;
  endtask

  task automatic s_frame(input logic [7:0] w, input int lc, input int pm);
    cfg_len = 2'(lc);
    par_en  = (pm != 0);
    par_odd = (pm == 2);
    s_bit(1'b1); s_bit(1'b1);
    s_bit(1'b0);
    for (int i = 0; i < 5 + lc; i++) s_bit(w[i]);
    if (pm != 0) s_bit(pbit_of(w, lc, pm));
    s_bit(1'b1);
    repeat (6) @(negedge clk);
  endtask

  task automatic ack();
    @(negedge clk); rd_ack = 1'b1;
    @(negedge clk); rd_ack = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] w;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 data", int'(rx_data), 0);
    chk("R1 full", int'(rx_full), 0);
    chk("R1 errs", int'({err_parity, err_frame, err_overrun}), 0);
    chk("R1 irq", int'(rx_irq), 0);

    // R2 R3 R5 R6: sweep over length, parity mode, word, idle phase
    for (int lc = 0; lc < 4; lc++) begin
      for (int pm = 0; pm < 3; pm++) begin
        for (int wi = 0; wi < 6; wi++) begin
          w = 8'((wi * 37 + lc * 11 + pm * 5 + 90) & 255);
          a_frame(w, lc, pm, 1'b0, 1'b1, (wi == 2), wi % 5);
          chk("R2 R3 R5 data", int'(rx_data), int'(w & lmask(lc)));
          chk("R2 full", int'(rx_full), 1);
          chk("R6 parity ok", int'(err_parity), 0);
          chk("R7 stop ok", int'(err_frame), 0);
          ack();
        end
      end
    end

    // R6 parity mismatch, even and odd
    a_frame(8'hA7, 3, 1, 1'b1, 1'b1, 1'b0, 0);
    chk("R6 even mismatch", int'(err_parity), 1);
    ack();
    a_frame(8'h3C, 1, 2, 1'b1, 1'b1, 1'b0, 2);
    chk("R6 odd mismatch", int'(err_parity), 1);
    ack();

    // R7 framing error
    a_frame(8'h5E, 3, 0, 1'b0, 1'b0, 1'b0, 1);
    chk("R7 frame err", int'(err_frame), 1);
    chk("R7 data kept", int'(rx_data), 8'h5E);
    ack();
    a_frame(8'h11, 3, 0, 1'b0, 1'b1, 1'b0, 0);
    chk("R7 frame clean", int'(err_frame), 0);
    ack();

    // R4 rejected start bit: low for two samples only
    tick_wait(1);
    rxd = 1'b0; tick_wait(2);
    rxd = 1'b1; tick_wait(12);
    chk("R4 no word", int'(rx_full), 0);
    a_frame(8'hC9, 3, 0, 1'b0, 1'b1, 1'b0, 0);
    chk("R4 later frame", int'(rx_data), 8'hC9);
    ack();

    // R8 overrun, R9 acknowledge
    a_frame(8'h12, 3, 0, 1'b0, 1'b1, 1'b0, 0);
    chk("R8 no ovr first", int'(err_overrun), 0);
    a_frame(8'h34, 3, 0, 1'b0, 1'b1, 1'b0, 0);
    chk("R8 overrun", int'(err_overrun), 1);
    chk("R8 newest", int'(rx_data), 8'h34);
    ack();
    chk("R9 full clr", int'(rx_full), 0);
    chk("R9 ovr clr", int'(err_overrun), 0);

    // R11 interrupt
    irq_en = 1'b1;
    a_frame(8'h6D, 3, 0, 1'b0, 1'b1, 1'b0, 0);
    chk("R11 irq on", int'(rx_irq), 1);
    ack();
    chk("R11 irq off", int'(rx_irq), 0);
    irq_en = 1'b0;
    a_frame(8'h6E, 3, 0, 1'b0, 1'b1, 1'b0, 0);
    chk("R11 masked", int'(rx_irq), 0);
    ack();

    // R10 synchronous mode sweep
    sync_mode = 1'b1;
    for (int lc = 0; lc < 4; lc++) begin
      for (int pm = 0; pm < 3; pm++) begin
        for (int wi = 0; wi < 2; wi++) begin
          w = 8'((wi * 149 + lc * 23 + pm * 7 + 41) & 255);
          s_frame(w, lc, pm);
          chk("R10 data", int'(rx_data), int'(w & lmask(lc)));
          chk("R10 full", int'(rx_full), 1);
          chk("R10 parity", int'(err_parity), 0);
          ack();
        end
      end
    end
    sync_mode = 1'b0;

    summary();
    $finish;
  end
endmodule